// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable model of a single-clock synchronous SRAM. Address, control and write data are captured on the rising clock edge. Read data flows out combinationally from the captured address within the same cycle, so there is no output register stage. Each word has four byte lanes, and every lane can carry a parity bit.

An access begins with one of two address strobes: a processor-side strobe and a controller-side strobe. Either one loads an external address into a two-bit burst sequencer. Later cycles either advance the sequencer or hold it, under control of an advance input. The sequencer steps in linear or interleaved order.

Three chip enables qualify each load. A global write forces all lanes to be written, and the per-lane enables select individual lanes otherwise. An asynchronous output enable gates the data output. An asynchronous sleep input freezes the block and keeps the array contents. The data output is a plain vector, with a separate flag that marks when the drivers would be in high impedance.

Top module: `fsb_sram`

## Requirements
- R1: After reset the output is in high impedance (`rdata_hiz`=1, `rdata`=0) and no burst is active.
- R2: A load selects the chip only when `ce_n`=0, `ce2`=1 and `ce3_n`=0. Two kinds of load deselect it: a processor-strobe load with `ce_n`=0 and another enable inactive, and a controller-strobe load with any enable inactive. A deselected chip keeps the output in high impedance and ignores writes until the next selecting load. The enables are ignored on cycles that load no address.
- R3: A processor strobe (`strobe_p_n`=0) sampled with `ce_n`=1 is ignored. The cycle then follows the controller strobe, or the continue/suspend rules if that strobe is also high. The processor strobe takes priority over the controller strobe when `ce_n`=0.
- R4: A selecting processor-strobe load always performs a read at `addr`, whatever the write inputs. The word appears on `rdata` after that edge, before the next edge. A write to that address is done on a following cycle.
- R5: A selecting controller-strobe load (`strobe_c_n`=0, `strobe_p_n`=1 or `ce_n`=1) writes `wdata` at `addr` on that same edge if any lane write is active. Otherwise it reads `addr`.
- R6: Lane write decode works as follows. `gw_n`=0 writes all four lanes, whatever `bwe_n` and `bw_n`. Otherwise `bwe_n`=0 writes each lane i whose `bw_n[i]`=0. Otherwise the cycle is a read. Lane i is `wdata[9i+8:9i]`, and bit 9i+8 is its parity bit.
- R7: The two low address bits step through a burst of four. Beat k after the load (k counted modulo 4) uses (start+k) mod 4 when `linear_mode`=1, and start XOR k when `linear_mode`=0. The upper address bits stay fixed.
- R8: On a cycle with no load while a burst is active, `adv_n`=0 moves to the next beat before the access, and `adv_n`=1 repeats the current address. Either cycle is a read or a write according to R6.
- R9: `oe_n`=1 forces `rdata_hiz`=1 at once, without a clock edge. With `oe_n`=0 a read cycle drives the word.
- R10: After a write cycle the output stays in high impedance, whatever `oe_n` is, until a cycle performs a read.
- R11: While `sleep`=1 the output is in high impedance and every other input is ignored. Array contents and burst state are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| sleep | input | 1 | Asynchronous low-power hold, active high |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high |
| ce3_n | input | 1 | Tertiary chip enable, active low |
| strobe_p_n | input | 1 | Processor-side address strobe, active low |
| strobe_c_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Lane-write qualifier, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| linear_mode | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr | input | AW | External word address |
| wdata | input | LANES*(BYTE_W+PAR_EN) | Write data, lane i at bits [9i+8:9i] |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*(BYTE_W+PAR_EN) | Read data, zero while in high impedance |
| rdata_hiz | output | 1 | 1 when the data drivers are off |

## Verification
The sequencer's beat counter and starting offset are hidden, but a wrong value shows on `rdata` in the very cycle that follows the faulty edge: the word read comes from the wrong location. A corrupted active flag or read flag shows at once as a wrong `rdata_hiz` level. A misdecoded lane write stays silent until that word is read back, so the bench re-reads every lane mask exhaustively and fills the whole array before running random traffic. State that should have been frozen by sleep is checked in the first read after sleep drops.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        CYC_CONT   = 2'd0,
        CYC_LOAD_P = 2'd1,
        CYC_LOAD_C = 2'd2
    } cyc_e;

    function automatic logic [BURST_W-1:0] burst_ofs(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] beat,
        input logic               linear
    );
        return linear ? (start + beat) : (start ^ beat);
    endfunction

endpackage

// File: rtl/fsb_cmd_dec.sv
module fsb_cmd_dec
    import fsb_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             ce_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             strobe_p_n,
    input  logic             strobe_c_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output cyc_e             cyc,
    output logic             sel,
    output logic [LANES-1:0] lane_we
);

    always_comb begin
        sel = !ce_n && ce2 && !ce3_n;
        if (!strobe_p_n && !ce_n) begin
            cyc = CYC_LOAD_P;
        end else if (!strobe_c_n) begin
            cyc = CYC_LOAD_C;
        end else begin
            cyc = CYC_CONT;
        end
        if (!gw_n) begin
            lane_we = '1;
        end else if (!bwe_n) begin
            lane_we = ~bw_n;
        end else begin
            lane_we = '0;
        end
    end

endmodule

// File: rtl/fsb_burst_seq.sv
module fsb_burst_seq
    import fsb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               linear,
    input  logic               load,
    input  logic [BURST_W-1:0] load_ofs,
    input  logic               step,
    output logic [BURST_W-1:0] cur_ofs,
    output logic [BURST_W-1:0] nxt_ofs
);

    typedef struct packed {
        logic [BURST_W-1:0] start;
        logic [BURST_W-1:0] beat;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (load) begin
            seq_d.start = load_ofs;
            seq_d.beat  = '0;
        end else if (step) begin
            seq_d.beat = seq_q.beat + 1'b1;
        end
        cur_ofs = burst_ofs(seq_q.start, seq_q.beat, linear);
        nxt_ofs = burst_ofs(seq_d.start, seq_d.beat, linear);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/fsb_array.sv
module fsb_array #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DEPTH  = 1 << AW,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic [LANES-1:0]  we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) begin
                mem_q[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = mem_q[raddr];
    end

endmodule

// File: rtl/fsb_sram.sv
module fsb_sram
    import fsb_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    parameter int PAR_EN = 1,
    localparam int LANE_W = BYTE_W + PAR_EN,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              ce_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              strobe_p_n,
    input  logic              strobe_c_n,
    input  logic              adv_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              linear_mode,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_hiz
);

    localparam int HI_W = AW - BURST_W;

    typedef struct packed {
        logic            act;
        logic            rd;
        logic [HI_W-1:0] base_hi;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    cyc_e               cyc;
    logic               sel;
    logic [LANES-1:0]   lane_we;
    logic [LANES-1:0]   wr_lanes;
    logic               seq_load;
    logic               seq_step;
    logic [BURST_W-1:0] cur_ofs;
    logic [BURST_W-1:0] nxt_ofs;
    logic [AW-1:0]      wr_addr;
    logic [AW-1:0]      rd_addr;
    logic [DATA_W-1:0]  arr_rdata;

    fsb_cmd_dec #(.LANES(LANES)) u_dec (
        .ce_n       (ce_n),
        .ce2        (ce2),
        .ce3_n      (ce3_n),
        .strobe_p_n (strobe_p_n),
        .strobe_c_n (strobe_c_n),
        .gw_n       (gw_n),
        .bwe_n      (bwe_n),
        .bw_n       (bw_n),
        .cyc        (cyc),
        .sel        (sel),
        .lane_we    (lane_we)
    );

    fsb_burst_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .linear   (linear_mode),
        .load     (seq_load),
        .load_ofs (addr[BURST_W-1:0]),
        .step     (seq_step),
        .cur_ofs  (cur_ofs),
        .nxt_ofs  (nxt_ofs)
    );

    // Next-state: loads, continue/suspend, sleep hold
    always_comb begin
        ctl_d    = ctl_q;
        seq_load = 1'b0;
        seq_step = 1'b0;
        wr_lanes = '0;
        if (!sleep) begin
            unique case (cyc)
                CYC_LOAD_P: begin
                    seq_load      = 1'b1;
                    ctl_d.base_hi = addr[AW-1:BURST_W];
                    ctl_d.act     = sel;
                    ctl_d.rd      = sel;
                end
                CYC_LOAD_C: begin
                    seq_load      = 1'b1;
                    ctl_d.base_hi = addr[AW-1:BURST_W];
                    ctl_d.act     = sel;
                    ctl_d.rd      = sel && !(|lane_we);
                    if (sel) begin
                        wr_lanes = lane_we;
                    end
                end
                default: begin
                    if (ctl_q.act) begin
                        seq_step = !adv_n;
                        ctl_d.rd = !(|lane_we);
                        wr_lanes = lane_we;
                    end
                end
            endcase
        end
        wr_addr = {ctl_d.base_hi, nxt_ofs};
        rd_addr = {ctl_q.base_hi, cur_ofs};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    fsb_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk   (clk),
        .we    (wr_lanes),
        .waddr (wr_addr),
        .wdata (wdata),
        .raddr (rd_addr),
        .rdata (arr_rdata)
    );

    // Flow-through output with asynchronous gating
    assign rdata_hiz = sleep | oe_n | ~ctl_q.act | ~ctl_q.rd;
    assign rdata     = rdata_hiz ? '0 : arr_rdata;

endmodule

// File: rtl/fsb_sram_chk.sv
module fsb_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep,
    input logic ce_n,
    input logic ce2,
    input logic ce3_n,
    input logic strobe_p_n,
    input logic strobe_c_n,
    input logic gw_n,
    input logic oe_n,
    input logic rdata_hiz
);

    // R9: disabled output enable means no drive
    p_oe_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> rdata_hiz);

    // R11: sleep turns the drivers off
    p_sleep_hiz_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> rdata_hiz);

    // R2: controller strobe with primary enable off deselects
    p_desel_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !strobe_c_n && ce_n) |=> rdata_hiz);

    // R10: a selecting controller-strobe global write leaves the output off
    p_write_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && strobe_p_n && !strobe_c_n && !ce_n && ce2 && !ce3_n && !gw_n)
        |=> rdata_hiz);

    // R4: a selecting processor-strobe load always reads
    p_pload_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !strobe_p_n && !ce_n && ce2 && !ce3_n)
        |=> (sleep || oe_n || !rdata_hiz));

endmodule

bind fsb_sram fsb_sram_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep      (sleep),
    .ce_n       (ce_n),
    .ce2        (ce2),
    .ce3_n      (ce3_n),
    .strobe_p_n (strobe_p_n),
    .strobe_c_n (strobe_c_n),
    .gw_n       (gw_n),
    .oe_n       (oe_n),
    .rdata_hiz  (rdata_hiz)
);

// File: tb/tb_fsb_sram.sv
`timescale 1ns/1ps
module tb_fsb_sram;

    localparam int AW    = 6;
    localparam int LANES = 4;
    localparam int LW    = 9;
    localparam int DW    = LANES * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sleep, ce_n, ce2, ce3_n, strobe_p_n, strobe_c_n, adv_n;
    logic          gw_n, bwe_n, linear_mode, oe_n;
    logic [3:0]    bw_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          rdata_hiz;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [DW-1:0] ref_mem [DEPTH];
    logic          r_act, r_rd;
    logic [AW-1:0] r_base;
    logic [1:0]    r_k;

    always #4 clk = ~clk;

    fsb_sram #(.AW(AW), .LANES(LANES), .BYTE_W(8), .PAR_EN(1)) dut (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .ce_n(ce_n), .ce2(ce2),
        .ce3_n(ce3_n), .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n),
        .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
        .linear_mode(linear_mode), .addr(addr), .wdata(wdata), .oe_n(oe_n),
        .rdata(rdata), .rdata_hiz(rdata_hiz)
    );

    function automatic logic [DW-1:0] pat(int a, int salt);
        logic [63:0] v;
        v = 64'(a + 1 + salt * 131) * 64'h9E37_79B9_7F4A_7C15;
        return v[58:23];
    endfunction

    function automatic int ref_addr();
        logic [1:0] lo;
        lo = linear_mode ? (r_base[1:0] + r_k) : (r_base[1:0] ^ r_k);
        return int'({r_base[AW-1:2], lo});
    endfunction

    task automatic ref_write(logic [3:0] wl);
        int a;
        a = ref_addr();
        for (int i = 0; i < LANES; i++) begin
            if (wl[i]) ref_mem[a][i*LW +: LW] = wdata[i*LW +: LW];
        end
    endtask

    task automatic ref_edge();
        logic [3:0] wl;
        logic s;
        if (sleep) return;
        s  = !ce_n && ce2 && !ce3_n;
        wl = !gw_n ? 4'hF : (!bwe_n ? ~bw_n : 4'h0);
        if (!strobe_p_n && !ce_n) begin
            r_base = addr; r_k = 2'd0; r_act = s; r_rd = s;
        end else if (!strobe_c_n) begin
            r_base = addr; r_k = 2'd0; r_act = s; r_rd = s && (wl == 4'h0);
            if (s) ref_write(wl);
        end else if (r_act) begin
            if (!adv_n) r_k = r_k + 2'd1;
            r_rd = (wl == 4'h0);
            ref_write(wl);
        end
    endtask

    task automatic check(string req);
        logic          exp_h;
        logic [DW-1:0] exp_d;
        exp_h = sleep || oe_n || !r_act || !r_rd;
        exp_d = exp_h ? '0 : ref_mem[ref_addr()];
        n_chk++;
        if (rdata_hiz !== exp_h || rdata !== exp_d) begin
            n_bad++;
            $display("FAIL %s: got hiz=%0b data=%h expected hiz=%0b data=%h",
                     req, rdata_hiz, rdata, exp_h, exp_d);
        end
    endtask

    task automatic tick(string req);
        @(posedge clk);
        ref_edge();
        @(negedge clk);
        check(req);
    endtask

    task automatic quiet();
        sleep = 0; ce_n = 0; ce2 = 1; ce3_n = 0;
        strobe_p_n = 1; strobe_c_n = 1; adv_n = 1;
        gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0;
    endtask

    task automatic cwrite(int a, logic [DW-1:0] d, string req);
        quiet(); strobe_c_n = 0; addr = AW'(a); gw_n = 0; wdata = d;
        tick(req);
    endtask

    task automatic pload(int a, string req);
        quiet(); strobe_p_n = 0; addr = AW'(a);
        tick(req);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hung run expected completion");
        finish_run();
    end

    initial begin
        quiet();
        linear_mode = 1; addr = '0; wdata = '0;
        r_act = 0; r_rd = 0; r_base = '0; r_k = 2'd0;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1;
        tick("R1 idle after reset");

        // R5/R6: fill whole array with global writes
        for (int a = 0; a < DEPTH; a++) cwrite(a, pat(a, 0), "R5 fill");

        // R7/R4/R8: burst order sweep, both modes, every start offset
        for (int m = 0; m < 2; m++) begin
            for (int off = 0; off < 4; off++) begin
                linear_mode = m[0];
                pload((m * 4 + off) * 4 + off, "R4 load read");
                for (int b = 0; b < 4; b++) begin
                    quiet(); adv_n = 0; tick("R7 burst beat");
                end
                quiet(); tick("R8 suspend");
            end
        end
        linear_mode = 1;

        // R4: processor load ignores write inputs, write follows on next cycle
        quiet(); strobe_p_n = 0; addr = 6'd20; gw_n = 0; wdata = pat(99, 1);
        tick("R4 load ignores write");
        quiet(); gw_n = 0; wdata = pat(20, 2); tick("R8 write current");
        quiet(); tick("R10 hiz after write");
        quiet(); adv_n = 0; tick("R8 advance read");
        quiet(); adv_n = 0; gw_n = 0; wdata = pat(22, 3); tick("R8 advance write");
        pload(20, "R8 readback");
        quiet(); adv_n = 0; tick("R8 readback 21");
        quiet(); adv_n = 0; tick("R8 readback 22");

        // R6: every lane mask, with and without qualifier, and global override
        for (int mk = 0; mk < 16; mk++) begin
            cwrite(40, pat(40, 10), "R6 base");
            quiet(); strobe_c_n = 0; addr = 6'd40; bwe_n = 0; bw_n = 4'(mk);
            wdata = pat(mk, 20); tick("R6 lane write");
            pload(40, "R6 lane mask readback");
            quiet(); strobe_c_n = 0; addr = 6'd41; bwe_n = 1; bw_n = 4'(mk);
            wdata = pat(mk, 30); tick("R6 no qualifier is read");
        end
        quiet(); strobe_c_n = 0; addr = 6'd41; gw_n = 0; bwe_n = 1;
        wdata = pat(41, 40); tick("R6 global override");
        pload(41, "R6 global readback");

        // R9: asynchronous output enable
        pload(12, "R9 read");
        oe_n = 1; #1; check("R9 oe off");
        oe_n = 0; #1; check("R9 oe on");
        @(negedge clk);

        // R10: write cycles keep output off even with oe_n low
        cwrite(13, pat(13, 50), "R10 write hiz");
        quiet(); gw_n = 0; adv_n = 0; wdata = pat(14, 50); tick("R10 continue write hiz");
        quiet(); tick("R10 read restores drive");

        // R2: each enable deselects at a load, enables ignored on continue
        pload(8, "R2 select");
        quiet(); ce2 = 0; ce_n = 1; adv_n = 0; tick("R2 enables ignored on continue");
        quiet(); strobe_p_n = 0; addr = 6'd9; ce2 = 0; tick("R2 ce2 deselect");
        quiet(); gw_n = 0; wdata = '1; tick("R2 write while deselected");
        pload(4, "R2 reselect");
        quiet(); strobe_p_n = 0; addr = 6'd9; ce3_n = 1; tick("R2 ce3 deselect");
        pload(4, "R2 reselect");
        quiet(); strobe_c_n = 0; ce_n = 1; addr = 6'd9; gw_n = 0; wdata = '1;
        tick("R2 controller deselect");
        pload(9, "R2 no stray write");

        // R3: processor strobe with ce_n high is ignored
        pload(16, "R3 load");
        quiet(); strobe_p_n = 0; ce_n = 1; addr = 6'd50; adv_n = 0; tick("R3 ignored continues");
        quiet(); strobe_p_n = 0; strobe_c_n = 0; ce_n = 1; addr = 6'd50; tick("R3 controller governs");
        pload(24, "R3 load");
        quiet(); strobe_p_n = 0; strobe_c_n = 0; addr = 6'd30; gw_n = 0; wdata = '1;
        tick("R3 processor priority");

        // R11: sleep freezes state and array
        pload(33, "R11 load");
        quiet(); sleep = 1; strobe_c_n = 0; addr = 6'd33; gw_n = 0; wdata = '1;
        tick("R11 sleep hiz");
        quiet(); sleep = 1; adv_n = 0; gw_n = 0; wdata = '1; tick("R11 sleep ignores continue");
        quiet(); tick("R11 state kept");
        quiet(); adv_n = 0; tick("R11 burst resumes");

        // R8: random traffic against the reference array
        for (int c = 0; c < 4000; c++) begin
            if (c % 500 == 0) linear_mode = ~linear_mode;
            sleep      = ($urandom % 40) == 0;
            strobe_p_n = ($urandom % 100) >= 12;
            strobe_c_n = ($urandom % 100) >= 12;
            ce_n       = ($urandom % 8) == 0;
            ce2        = ($urandom % 8) != 0;
            ce3_n      = ($urandom % 8) == 0;
            adv_n      = 1'($urandom % 2);
            gw_n       = ($urandom % 6) != 0;
            bwe_n      = 1'($urandom % 2);
            bw_n       = 4'($urandom % 16);
            addr       = AW'($urandom % DEPTH);
            wdata      = DW'({$urandom, $urandom});
            oe_n       = ($urandom % 6) == 0;
            tick("R8 random mix");
        end

        finish_run();
    end

endmodule